// File: doc/BRIEF.md
# Short-Jump-to-Skip Fetch Filter

This block sits in the instruction path of a small core that runs code in place from a serial flash. The flash is read strictly in address order. The block inspects every opcode on its way to the decoder. Most opcodes pass straight through with no added latency. It handles two kinds of control opcode itself: native conditional skips, and conditional jumps.

A taken skip, or a taken jump that lands one to four opcodes ahead, does not stop the sequential stream. The block keeps accepting opcodes and silently discards the ones the jump would have stepped over. Only a taken jump outside that short forward range raises a redirect request, which tells the flash controller where to restart reading. The block counts the address of every opcode it accepts, so that each request carries an absolute target.

Top module: `skip_fetch`

## Requirements
- R1: After reset no output is valid, no redirect is requested, no drop window is open, and the address of the first accepted opcode is 0.
- R2: An opcode whose class (bits 15:12) is neither 4'hA nor 4'hB, arriving outside a drop window, is passed through in the same cycle: out_valid equals in_valid, out_data equals in_data, and in_ready equals out_ready.
- R3: A skip opcode (class 4'hB) accepted while cond is 1 discards the next K opcodes, where K = bits 1:0 plus one (1 to 4). While discarding, in_ready is 1 and out_valid is 0.
- R4: A skip or jump opcode accepted while cond is 0 is consumed. Nothing is discarded and no redirect is raised.
- R5: A jump opcode (class 4'hA, signed 12-bit offset in bits 11:0) accepted while cond is 1 with an offset of 1 to 4 discards exactly that many following opcodes and raises no redirect.
- R6: A jump accepted while cond is 1 with any other offset (0, above 4, or negative) discards nothing. In the next cycle it raises redirect_valid with redirect_addr equal to the jump's own address plus 1 plus the offset.
- R7: Skip and jump opcodes are never shown on the output. They are accepted in the cycle they are presented, whatever the value of out_ready.
- R8: A skip or jump opcode that arrives inside an open drop window is dropped without being evaluated. It neither raises a redirect nor lengthens the window.
- R9: Every accepted opcode advances the tracked address by one, including dropped ones. After a redirect, the next accepted opcode is taken to sit at the redirect target.
- R10: redirect_valid is high for exactly one cycle per far taken jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode from the serial fetch stream is valid |
| in_ready | output | 1 | Opcode is accepted this cycle |
| in_data | input | 16 | Opcode from the fetch stream |
| cond | input | 1 | Condition flag, sampled with a skip or jump opcode |
| out_valid | output | 1 | Opcode to the decoder is valid |
| out_ready | input | 1 | Decoder takes the opcode |
| out_data | output | 16 | Opcode to the decoder |
| redirect_valid | output | 1 | One-cycle request to restart the fetch |
| redirect_addr | output | 16 | Opcode address at which to restart the fetch |

## Verification
On every cycle the embedded assertions check four things. Control classes never reach the decoder. Pass-through follows decoder backpressure. A taken skip opens a silent window of bounded length. A false condition leaves no window and no redirect behind. Three behaviours can only be shown by the bench's directed scenarios, because they are counts and values over a run of opcodes. These are the exact number of opcodes dropped for each skip and jump length, the absolute redirect address for zero, far and backward offsets, and the carry of the tracked address across one redirect into the next.

// File: rtl/skip_fetch.sv
module skip_fetch #(
  parameter int OP_W     = 16,
  parameter int ADDR_W   = 16,
  parameter int CLS_W    = 4,
  parameter int MAX_SKIP = 4,
  parameter logic [CLS_W-1:0] JMP_CLS = 4'hA,
  parameter logic [CLS_W-1:0] SKP_CLS = 4'hB,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_data,
  input  logic              cond,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OP_W-1:0]   out_data,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  localparam int OFF_W = OP_W - CLS_W;
  localparam int CNT_W = $clog2(MAX_SKIP + 1);
  localparam int SKC_W = $clog2(MAX_SKIP);

  logic [CNT_W-1:0]  drop_cnt;
  logic [ADDR_W-1:0] pc;

  wire [CLS_W-1:0] cls      = in_data[OP_W-1 -: CLS_W];
  wire [OFF_W-1:0] off      = in_data[OFF_W-1:0];
  wire             is_jmp   = (cls == JMP_CLS);
  wire             is_skp   = (cls == SKP_CLS);
  wire             is_ctl   = is_jmp | is_skp;
  wire             dropping = (drop_cnt != '0);
  wire             accept   = in_valid & in_ready;
  wire             taken    = accept & ~dropping & is_ctl & cond;

  wire short_jmp = ~off[OFF_W-1] && (off != '0) && (off <= OFF_W'(MAX_SKIP));
  wire far_jmp   = taken & is_jmp & ~short_jmp;

  wire [ADDR_W-1:0] off_ext = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  wire [ADDR_W-1:0] target  = pc + ADDR_W'(1) + off_ext;

  assign in_ready  = (dropping | is_ctl) ? 1'b1 : out_ready;
  assign out_valid = in_valid & ~dropping & ~is_ctl;
  assign out_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_cnt       <= '0;
      pc             <= RESET_PC;
      redirect_valid <= 1'b0;
      redirect_addr  <= '0;
    end else begin
      redirect_valid <= far_jmp;
      if (far_jmp) redirect_addr <= target;
      if (accept) pc <= far_jmp ? target : pc + ADDR_W'(1);
      if (taken && is_skp)
        drop_cnt <= CNT_W'(in_data[SKC_W-1:0]) + CNT_W'(1);
      else if (taken && is_jmp && short_jmp)
        drop_cnt <= off[CNT_W-1:0];
      else if (accept && dropping)
        drop_cnt <= drop_cnt - CNT_W'(1);
    end
  end

  assert_ctl_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[OP_W-1 -: CLS_W] != JMP_CLS && out_data[OP_W-1 -: CLS_W] != SKP_CLS));

  assert_passthru_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dropping && !is_ctl) |-> (in_ready == out_ready));

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && is_skp) |=> (!out_valid && in_ready));

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt <= CNT_W'(MAX_SKIP));

  assert_false_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dropping && is_ctl && !cond) |=> (!dropping && !redirect_valid));

  assert_redir_no_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !dropping);

  assert_window_no_redir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dropping) |=> !redirect_valid);
endmodule

// File: tb/skip_fetch_tb.sv
`timescale 1ns/1ps
module skip_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        cond = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        redirect_valid;
  logic [15:0] redirect_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] addr_m = '0;

  always #2.5 clk = ~clk;

  skip_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cond(cond), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] op(input logic [3:0] c, input logic [11:0] f);
    return {c, f};
  endfunction

  task automatic push(input logic [15:0] d, input logic c, input logic r,
                      input logic exp_pass, input string tag);
    logic acc;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; cond = c; out_ready = r;
    #1;
    acc = exp_pass ? r : 1'b1;
    chk({tag, " out_valid"}, out_valid, exp_pass);
    chk({tag, " in_ready"}, in_ready, acc);
    if (exp_pass) chk({tag, " out_data"}, out_data, d);
    @(posedge clk);
    if (acc) addr_m = addr_m + 16'd1;
  endtask

  task automatic idle_redir(input logic exp_v, input logic [15:0] exp_a, input string tag);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk({tag, " redirect_valid"}, redirect_valid, exp_v);
    if (exp_v) chk({tag, " redirect_addr"}, redirect_addr, exp_a);
    @(posedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 redirect after reset", redirect_valid, 0);
    addr_m = '0;
    push(op(4'h1, 12'h011), 1'b1, 1'b1, 1'b1, "R1 first opcode passes");
    push(op(4'hA, 12'h010), 1'b1, 1'b1, 1'b0, "R1 far jump at address 1");
    idle_redir(1'b1, 16'd18, "R1 first address zero");
    addr_m = 16'd18;
  endtask

  task automatic t_pass();
    push(op(4'h2, 12'h123), 1'b1, 1'b1, 1'b1, "R2 pass ready");
    push(op(4'h3, 12'h456), 1'b0, 1'b0, 1'b1, "R2 pass stalled");
    push(op(4'h3, 12'h456), 1'b0, 1'b1, 1'b1, "R2 pass resumed");
    push(op(4'hF, 12'hFFF), 1'b1, 1'b1, 1'b1, "R2 pass top class");
  endtask

  task automatic t_skip();
    for (int n = 1; n <= 4; n++) begin
      push(op(4'hB, 12'(n - 1)), 1'b1, 1'b1, 1'b0, "R3 skip opcode");
      for (int k = 0; k < n; k++)
        push(op(4'h5, 12'(k)), 1'b0, 1'b0, 1'b0, "R3 dropped opcode");
      push(op(4'h6, 12'(n)), 1'b0, 1'b1, 1'b1, "R3 resume after skip");
    end
  endtask

  task automatic t_false();
    push(op(4'hB, 12'h003), 1'b0, 1'b1, 1'b0, "R4 false skip consumed");
    push(op(4'h7, 12'h001), 1'b1, 1'b1, 1'b1, "R4 next passes after false skip");
    push(op(4'hA, 12'h002), 1'b0, 1'b0, 1'b0, "R7 false jump consumed with out_ready low");
    idle_redir(1'b0, '0, "R4 no redirect on false jump");
    push(op(4'h7, 12'h002), 1'b1, 1'b1, 1'b1, "R4 next passes after false jump");
    push(op(4'hA, 12'h100), 1'b0, 1'b1, 1'b0, "R4 false far jump");
    idle_redir(1'b0, '0, "R4 no redirect on false far jump");
  endtask

  task automatic t_short();
    push(op(4'hA, 12'h001), 1'b1, 1'b1, 1'b0, "R5 jump +1");
    idle_redir(1'b0, '0, "R5 no redirect +1");
    push(op(4'h8, 12'h000), 1'b1, 1'b1, 1'b0, "R5 one dropped");
    push(op(4'h8, 12'h001), 1'b1, 1'b1, 1'b1, "R5 resume after +1");
    push(op(4'hA, 12'h004), 1'b1, 1'b0, 1'b0, "R5 jump +4");
    for (int k = 0; k < 4; k++)
      push(op(4'h9, 12'(k)), 1'b1, 1'b1, 1'b0, "R5 dropped of four");
    push(op(4'h9, 12'h004), 1'b1, 1'b1, 1'b1, "R5 resume after +4");
  endtask

  task automatic t_far();
    logic [15:0] tgt;
    tgt = addr_m + 16'd6;
    push(op(4'hA, 12'h005), 1'b1, 1'b1, 1'b0, "R6 jump +5");
    idle_redir(1'b1, tgt, "R6 redirect +5");
    idle_redir(1'b0, '0, "R10 redirect lasts one cycle");
    addr_m = tgt;
    push(op(4'h1, 12'h000), 1'b1, 1'b1, 1'b1, "R6 no drop after far jump");
    tgt = addr_m + 16'd1 - 16'd3;
    push(op(4'hA, 12'hFFD), 1'b1, 1'b1, 1'b0, "R9 backward jump after redirect");
    idle_redir(1'b1, tgt, "R9 backward target");
    addr_m = tgt;
    tgt = addr_m + 16'd1;
    push(op(4'hA, 12'h000), 1'b1, 1'b1, 1'b0, "R6 zero offset jump");
    idle_redir(1'b1, tgt, "R6 zero offset target");
    idle_redir(1'b0, '0, "R10 zero offset pulse ends");
    addr_m = tgt;
  endtask

  task automatic t_nested();
    push(op(4'hB, 12'h001), 1'b1, 1'b1, 1'b0, "R8 skip two");
    push(op(4'hA, 12'h040), 1'b1, 1'b1, 1'b0, "R8 far jump in window dropped");
    idle_redir(1'b0, '0, "R8 no redirect from window");
    push(op(4'hB, 12'h003), 1'b1, 1'b1, 1'b0, "R8 skip in window dropped");
    push(op(4'h4, 12'h0AA), 1'b1, 1'b1, 1'b1, "R8 window not extended");
    push(op(4'hA, 12'h020), 1'b1, 1'b1, 1'b0, "R9 far jump after drops");
    idle_redir(1'b1, addr_m - 16'd1 + 16'd33, "R9 address counts dropped");
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_skip();
    t_false();
    t_short();
    t_far();
    t_nested();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule